// File: doc/BRIEF.md
# Serial Byte Collector with Host-Clocked Readout

This block sits after a 1200 baud FSK demodulator. It watches the recovered bit stream while the carrier-valid flag is set. It finds each asynchronous character, samples every bit at its centre, drops the start and stop bits and keeps the eight data bits. The finished byte is loaded into an eight-bit shift register. An active-low ready flag then drops to tell a host that a new word is waiting.

The host reads the byte through its own slow clock input. The bit received first is already on the data output when the byte is loaded. Each rising host clock edge moves the output on to the next bit. The first host edge also raises the ready flag, so the interrupt is cleared by the first read. If no host edge comes, the flag rises by itself after half a bit time. When carrier is absent or the block is powered down, no word is taken and the ready flag stays high.

Top module: `fsk_byte_reader`

## Requirements
- R1: After reset `ready_n` is 1 and `rd_data` is 0.
- R2: In the idle state a low level on `rx_bit` starts a character only if it is still low at the centre of the start bit, `BIT_CLKS/2` clocks later. A shorter low pulse produces no word.
- R3: The eight data bits are sampled one bit period apart at their centres. The stop bit is discarded. The byte is loaded at the sample of the eighth data bit, and `ready_n` goes to 0 on that clock edge.
- R4: Right after the load, `rd_data` shows the first received bit (b0, the byte's least significant bit). Each synchronized rising edge of `host_clk` advances `rd_data` to b1, b2 and so on up to b7, in the order the bits arrived.
- R5: A rising edge of `host_clk` while `ready_n` is 0 returns `ready_n` to 1 within four system clocks.
- R6: Without a host edge, `ready_n` stays 0 for exactly `BIT_CLKS/2` system clocks and then returns to 1.
- R7: Once `rd_data` has advanced to b7, further `host_clk` edges leave it at b7 until the next byte is loaded.
- R8: While `carrier_ok` is 0, the framing is abandoned. No byte is loaded, `ready_n` stays 1 and `rd_data` keeps its value.
- R9: While `pwr_down` is 1, `ready_n` is 1 from the next clock on, and no character is framed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down request; holds ready high and idles framing |
| rx_bit | input | 1 | Demodulated serial stream, 1 = mark |
| carrier_ok | input | 1 | High while a valid carrier is present |
| host_clk | input | 1 | Asynchronous host read clock |
| rd_data | output | 1 | Current bit of the loaded byte |
| ready_n | output | 1 | Active-low word-ready flag |

## Verification
The bench builds the block with `BIT_CLKS = 16`. A whole character therefore takes 160 clocks, and the half-bit ready window is 8 clocks. This makes the full window measurable cycle by cycle. It also leaves room to tell an early clear by the host (about 3 clocks) from the timeout. The short bit period lets the bench send many bytes, runt start pulses, and frames under carrier loss and power-down within a short run.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int WORD_BITS = 8;

    typedef logic [WORD_BITS-1:0] word_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } frame_state_e;

    typedef struct packed {
        logic  valid;
        word_t data;
    } word_evt_t;

    function automatic int half_of(input int n);
        return (n / 2 < 1) ? 1 : n / 2;
    endfunction

endpackage

// File: rtl/fbr_edge_sync.sv
module fbr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[DEPTH-2:0], async_in};
        end
    end

    assign rise = pipe[DEPTH-2] & ~pipe[DEPTH-1];
endmodule

// File: rtl/fbr_framer.sv
module fbr_framer
    import fbr_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      rx_bit,
    output word_evt_t evt
);
    localparam int HALF = half_of(BIT_CLKS);
    localparam int CW   = $clog2(BIT_CLKS + 1);
    localparam int IW   = $clog2(WORD_BITS);

    frame_state_e  st;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    word_t         acc;
    logic          at_mid;
    logic          at_half;
    logic          last_bit;

    assign at_mid   = (cnt == CW'(BIT_CLKS));
    assign at_half  = (cnt == CW'(HALF));
    assign last_bit = (idx == IW'(WORD_BITS - 1));

    assign evt.valid = enable && (st == FR_DATA) && at_mid && last_bit;
    assign evt.data  = {rx_bit, acc[WORD_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st  <= FR_IDLE;
            cnt <= '0;
            idx <= '0;
            if (rst) acc <= '0;
        end else begin
            unique case (st)
                FR_IDLE: begin
                    cnt <= CW'(1);
                    if (!rx_bit) st <= FR_START;
                end
                FR_START: begin
                    if (at_half) begin
                        if (!rx_bit) begin
                            st  <= FR_DATA;
                            cnt <= CW'(1);
                            idx <= '0;
                        end else begin
                            st <= FR_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                FR_DATA: begin
                    if (at_mid) begin
                        acc <= {rx_bit, acc[WORD_BITS-1:1]};
                        cnt <= CW'(1);
                        if (last_bit) st <= FR_STOP;
                        else          idx <= idx + IW'(1);
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                FR_STOP: begin
                    if (at_mid) st <= FR_IDLE;
                    else        cnt <= cnt + CW'(1);
                end
                default: st <= FR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fbr_readout.sv
module fbr_readout
    import fbr_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_down,
    input  word_evt_t evt,
    input  logic      host_rise,
    output logic      data_out,
    output logic      ready_n
);
    localparam int HALF = half_of(BIT_CLKS);
    localparam int DW   = $clog2(HALF + 1);
    localparam int SW   = $clog2(WORD_BITS);

    word_t         sr;
    logic [SW-1:0] adv;
    logic [DW-1:0] dcnt;

    assign data_out = sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            adv     <= '0;
            dcnt    <= '0;
            ready_n <= 1'b1;
        end else begin
            if (evt.valid) begin
                sr  <= evt.data;
                adv <= '0;
            end else if (host_rise && adv != SW'(WORD_BITS - 1)) begin
                sr  <= {1'b0, sr[WORD_BITS-1:1]};
                adv <= adv + SW'(1);
            end

            if (pwr_down) begin
                ready_n <= 1'b1;
            end else if (evt.valid) begin
                ready_n <= 1'b0;
                dcnt    <= '0;
            end else if (!ready_n) begin
                if (host_rise || dcnt == DW'(HALF - 1)) ready_n <= 1'b1;
                else                                    dcnt    <= dcnt + DW'(1);
            end
        end
    end
endmodule

// File: rtl/fsk_byte_reader.sv
module fsk_byte_reader
    import fbr_pkg::*;
#(
    parameter int BIT_CLKS    = 41667,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic rx_bit,
    input  logic carrier_ok,
    input  logic host_clk,
    output logic rd_data,
    output logic ready_n
);
    word_evt_t evt;
    logic      host_rise;
    logic      enable;

    assign enable = carrier_ok & ~pwr_down;

    fbr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (host_clk),
        .rise     (host_rise)
    );

    fbr_framer #(.BIT_CLKS(BIT_CLKS)) u_framer (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .rx_bit (rx_bit),
        .evt    (evt)
    );

    fbr_readout #(.BIT_CLKS(BIT_CLKS)) u_readout (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .evt       (evt),
        .host_rise (host_rise),
        .data_out  (rd_data),
        .ready_n   (ready_n)
    );
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker
    import fbr_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input logic clk,
    input logic rst,
    input logic pwr_down,
    input logic carrier_ok,
    input logic ready_n
);
    localparam int HALF = half_of(BIT_CLKS);
    localparam int LW   = $clog2(HALF + 2) + 1;

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || ready_n) low_run <= '0;
        else                low_run <= low_run + LW'(1);
    end

    // R9: power-down forces the ready flag high
    assert_dr_high_in_pd_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> ready_n);

    // R8: no ready pulse can start without carrier
    assert_no_dr_without_carrier_R8: assert property (@(posedge clk) disable iff (rst)
        (!carrier_ok && ready_n) |=> ready_n);

    // R8/R9: a falling ready flag needs carrier and no power-down one edge earlier
    assert_fall_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_n) |-> ($past(carrier_ok) && !$past(pwr_down)));

    // R6: a ready pulse never lasts longer than half a bit
    assert_dr_width_R6: assert property (@(posedge clk) disable iff (rst)
        low_run <= LW'(HALF));
endmodule

bind fsk_byte_reader fbr_checker #(.BIT_CLKS(BIT_CLKS)) u_fbr_checker (
    .clk        (clk),
    .rst        (rst),
    .pwr_down   (pwr_down),
    .carrier_ok (carrier_ok),
    .ready_n    (ready_n)
);

// File: tb/tb_fsk_byte_reader.sv
module tb_fsk_byte_reader;
    localparam int N    = 16;
    localparam int HALF = N / 2;
    localparam int NV   = 6;
    localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_down = 1'b0;
    logic rx_bit = 1'b1;
    logic carrier_ok = 1'b1;
    logic host_clk = 1'b0;
    logic rd_data;
    logic ready_n;

    int total = 0;
    int bad   = 0;
    int low_cnt = 0;
    logic exp_data;

    always #10 clk = ~clk;

    always @(negedge clk) if (!ready_n) low_cnt <= low_cnt + 1;

    fsk_byte_reader #(.BIT_CLKS(N)) dut (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .rx_bit(rx_bit),
        .carrier_ok(carrier_ok), .host_clk(host_clk),
        .rd_data(rd_data), .ready_n(ready_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b);
        rx_bit = 1'b0;
        repeat (N) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_bit = b[i];
            repeat (N) @(negedge clk);
        end
        rx_bit = 1'b1;
        repeat (N) @(negedge clk);
    endtask

    task automatic wait_ready_low();
        do @(negedge clk); while (ready_n);
    endtask

    task automatic host_pulse();
        host_clk = 1'b1;
        repeat (4) @(negedge clk);
        host_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // reads a byte with host clocks; checks R3/R4 value, R5 early clear, R7 hold
    task automatic read_byte(input logic [7:0] exp);
        logic [7:0] got;
        wait_ready_low();
        for (int k = 0; k < 8; k++) begin
            got[k] = rd_data;
            host_clk = 1'b1;
            repeat (4) @(negedge clk);
            if (k == 0) chk(ready_n == 1'b1, "R5 early clear", ready_n, 1);
            host_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        chk(got == exp, "R3 R4 byte order", got, exp);
        for (int j = 0; j < 3; j++) host_pulse();
        chk(rd_data == exp[7], "R7 extra clocks ignored", rd_data, exp[7]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready_n == 1'b1, "R1 ready after reset", ready_n, 1);
        chk(rd_data == 1'b0, "R1 data after reset", rd_data, 0);

        // table-driven bytes
        for (int v = 0; v < NV; v++) begin
            fork
                send_frame(VEC[v]);
                read_byte(VEC[v]);
            join
        end

        // R6: untouched ready window, and R4 b0 on load
        fork
            send_frame(8'hC3);
            begin
                wait_ready_low();
                chk(rd_data == 1'b1, "R4 b0 at load", rd_data, 1);
                repeat (HALF - 1) @(negedge clk);
                chk(ready_n == 1'b0, "R6 still low", ready_n, 0);
                @(negedge clk);
                chk(ready_n == 1'b1, "R6 released", ready_n, 1);
            end
        join
        exp_data = 1'b1;

        // R8: no carrier
        carrier_ok = 1'b0;
        snap = low_cnt;
        send_frame(8'h00);
        repeat (20) @(negedge clk);
        chk(low_cnt == snap, "R8 no ready without carrier", low_cnt - snap, 0);
        chk(rd_data == exp_data, "R8 data unchanged", rd_data, exp_data);
        carrier_ok = 1'b1;
        repeat (4) @(negedge clk);

        // R9: powered down frame
        pwr_down = 1'b1;
        snap = low_cnt;
        send_frame(8'h00);
        repeat (20) @(negedge clk);
        chk(low_cnt == snap, "R9 no ready in power-down", low_cnt - snap, 0);
        chk(rd_data == exp_data, "R9 data unchanged", rd_data, exp_data);
        pwr_down = 1'b0;
        repeat (4) @(negedge clk);

        // R9: power-down while ready is low
        fork
            send_frame(8'hF0);
            begin
                wait_ready_low();
                pwr_down = 1'b1;
                @(negedge clk);
                chk(ready_n == 1'b1, "R9 forced high", ready_n, 1);
                @(negedge clk);
                pwr_down = 1'b0;
            end
        join
        repeat (4) @(negedge clk);

        // R2: runt start pulse
        snap = low_cnt;
        rx_bit = 1'b0;
        repeat (HALF - 2) @(negedge clk);
        rx_bit = 1'b1;
        repeat (12 * N) @(negedge clk);
        chk(low_cnt == snap, "R2 runt start rejected", low_cnt - snap, 0);

        // R2/R3: a normal byte still frames after the runt
        fork
            send_frame(8'h6B);
            read_byte(8'h6B);
        join

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule